// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block sits on a host's byte-wide bus and offers three general-purpose parallel ports. Ports A and B are 8 bits wide. Port C is 8 bits wide but is steered as two independent 4-bit halves. The host selects the block with an active-low chip select and moves data with active-low read and write strobes. Two address bits pick one of three port latches or the configuration register. Pad tristating is modelled with separate pin-input, pin-output and output-enable vectors for each port. The host data bus is modelled the same way, with separate input, output and output-enable signals.

A bus sequencer with three states handles the strobes. The states are BUS_IDLE, BUS_WRITE and BUS_READ.

- BUS_IDLE moves to BUS_WRITE when the block is selected and the write strobe is low. The write is committed on that transition, and only on that transition.
- If no write is pending, BUS_IDLE moves to BUS_READ when the block is selected and the read strobe is low.
- BUS_WRITE returns to BUS_IDLE once the block is deselected or the write strobe rises.
- BUS_READ returns to BUS_IDLE once the block is deselected or the read strobe rises.

A configuration byte with its top bit set is a mode word. It sets the direction of each port group and clears all output latches. A configuration byte with its top bit clear is a single-pin command that sets or clears one port C latch bit.

Top module: `tri_port_pio`

## Requirements
- R1: While `cs_n` is high, no write changes any register and `dout_oe` stays low.
- R2: When `cs_n` and `rd_n` go low (with `wr_n` high), `dout_oe` rises after one clock edge and `dout` carries the selected data. `dout_oe` falls in the same cycle that `rd_n` or `cs_n` rises.
- R3: Address 0 selects port A, address 1 selects port B, address 2 selects port C and address 3 selects the configuration register. A port write loads that port's output latch, and the latch always appears on the port's `_out` pins.
- R4: Reset loads the configuration value 9Bh, which makes every port an input. Reset also clears every output latch.
- R5: Four configuration bits set the directions, with 1 meaning input. Bit 4 controls port A, bit 1 controls port B, bit 3 controls the upper half of port C and bit 0 controls the lower half of port C. An output group drives all ones on its `_oe` bits, and an input group drives all zeros.
- R6: Reading a port that is an input returns its pins. Reading a port that is an output returns its latch. Port C applies this rule to each half separately.
- R7: A configuration write with bit 7 = 1 stores the whole byte, which reads back unchanged from address 3. It also clears all three output latches.
- R8: A configuration write with bit 7 = 0 leaves the stored configuration unchanged. It writes bit 0 into the port C latch bit numbered by bits 3:1.
- R9: Configuration bit 2 and bits 6:5 are stored and read back, but they have no effect on direction or data. Ports always behave as simple I/O.
- R10: If `rd_n` and `wr_n` are both low as a cycle starts from idle, the write is performed and `dout_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | DATA_W | Host write data |
| dout | output | DATA_W | Host read data |
| dout_oe | output | 1 | Host data bus drive enable |
| pa_in | input | DATA_W | Port A pin input |
| pa_out | output | DATA_W | Port A latch output |
| pa_oe | output | DATA_W | Port A drive enable |
| pb_in | input | DATA_W | Port B pin input |
| pb_out | output | DATA_W | Port B latch output |
| pb_oe | output | DATA_W | Port B drive enable |
| pc_in | input | DATA_W | Port C pin input |
| pc_out | output | DATA_W | Port C latch output |
| pc_oe | output | DATA_W | Port C drive enable |

## Verification
The bench builds the block with DATA_W = 8. At that width the pin-number field of a single-pin command spans exactly bits 3:1, so every port C pin, in both halves, can be reached by set and clear commands. The 8-bit width also gives the 4/4 split of port C that the mixed-direction words rely on.

The mode words 80h, 98h, 9Bh, A4h and D0h together cover every direction combination used. These include mixed-direction port C reads and mode-1 and mode-2 codes that must degrade to simple I/O.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_e;

    localparam logic [1:0] SEL_A    = 2'd0;
    localparam logic [1:0] SEL_B    = 2'd1;
    localparam logic [1:0] SEL_C    = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int DIR_A  = 4;
    localparam int DIR_B  = 1;
    localparam int DIR_CU = 3;
    localparam int DIR_CL = 0;
    localparam int KIND   = 7;

    localparam logic [7:0] CFG_RESET = 8'h9B;
endpackage

// File: rtl/tpp_bus_fsm.sv
module tpp_bus_fsm
    import tpp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_drive
);
    bus_state_e state_q, state_d;
    logic       sel;

    assign sel = ~cs_n;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (sel && !wr_n)      state_d = BUS_WRITE;
                else if (sel && !rd_n) state_d = BUS_READ;
            end
            BUS_READ:  if (!sel || rd_n) state_d = BUS_IDLE;
            BUS_WRITE: if (!sel || wr_n) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = (state_q == BUS_IDLE) && (state_d == BUS_WRITE);
        rd_drive = (state_q == BUS_READ) && sel && !rd_n;
    end
endmodule

// File: rtl/tpp_mode_reg.sv
module tpp_mode_reg
    import tpp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pulse,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] mode_q,
    output logic              mode_wr,
    output logic              bit_wr,
    output logic [SEL_W-1:0]  bit_sel,
    output logic              bit_val
);
    logic ctrl_hit;

    always_comb begin
        ctrl_hit = wr_pulse && (addr == SEL_CTRL);
        mode_wr  = ctrl_hit && din[KIND];
        bit_wr   = ctrl_hit && !din[KIND];
        bit_sel  = din[SEL_W:1];
        bit_val  = din[0];
    end

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= DATA_W'(CFG_RESET);
        else if (mode_wr) mode_q <= din;
    end
endmodule

// File: rtl/tpp_port_latch.sv
module tpp_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic [W-1:0] bit_mask,
    input  logic         bit_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clear) q <= '0;
        else if (load)    q <= din;
        else              q <= (q & ~bit_mask) | (bit_mask & {W{bit_val}});
    end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import tpp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    localparam int NIB    = DATA_W / 2;
    localparam int SEL_W  = $clog2(DATA_W);
    localparam int NPORTS = 3;

    logic              wr_pulse, rd_drive;
    logic [DATA_W-1:0] mode_q;
    logic              mode_wr, bit_wr, bit_val;
    logic [SEL_W-1:0]  bit_sel;
    logic [DATA_W-1:0] c_mask;
    logic [DATA_W-1:0] latch_q [NPORTS];
    logic              a_in, b_in, cu_in, cl_in;
    logic [DATA_W-1:0] rd_val;

    tpp_bus_fsm u_bus (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse),
        .rd_drive (rd_drive)
    );

    tpp_mode_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .addr     (addr),
        .din      (din),
        .mode_q   (mode_q),
        .mode_wr  (mode_wr),
        .bit_wr   (bit_wr),
        .bit_sel  (bit_sel),
        .bit_val  (bit_val)
    );

    assign c_mask = bit_wr ? (DATA_W'(1) << bit_sel) : '0;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        tpp_port_latch #(.W(DATA_W)) u_latch (
            .clk      (clk),
            .rst      (rst),
            .clear    (mode_wr),
            .load     (wr_pulse && (addr == 2'(g))),
            .din      (din),
            .bit_mask ((g == 2) ? c_mask : '0),
            .bit_val  (bit_val),
            .q        (latch_q[g])
        );
    end

    always_comb begin
        a_in  = mode_q[DIR_A];
        b_in  = mode_q[DIR_B];
        cu_in = mode_q[DIR_CU];
        cl_in = mode_q[DIR_CL];
        pa_out = latch_q[0];
        pb_out = latch_q[1];
        pc_out = latch_q[2];
        pa_oe  = {DATA_W{~a_in}};
        pb_oe  = {DATA_W{~b_in}};
        pc_oe  = {{NIB{~cu_in}}, {NIB{~cl_in}}};
    end

    always_comb begin
        unique case (addr)
            SEL_A:    rd_val = a_in ? pa_in : latch_q[0];
            SEL_B:    rd_val = b_in ? pb_in : latch_q[1];
            SEL_C:    rd_val = {cu_in ? pc_in[DATA_W-1:NIB] : latch_q[2][DATA_W-1:NIB],
                                cl_in ? pc_in[NIB-1:0]      : latch_q[2][NIB-1:0]};
            default:  rd_val = mode_q;
        endcase
        dout_oe = rd_drive;
        dout    = rd_drive ? rd_val : '0;
    end
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cs_n,
    input logic         rd_n,
    input logic         dout_oe,
    input logic         wr_pulse,
    input logic [1:0]   addr,
    input logic [W-1:0] din,
    input logic [W-1:0] mode_q,
    input logic [W-1:0] pa_oe,
    input logic [W-1:0] pc_oe
);
    // R1
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(mode_q));

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dout_oe);

    // R2
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!rd_n && !cs_n));

    // R4
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == W'(8'h9B) && pa_oe == '0 && pc_oe == '0));

    // R5
    group_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0) || (pa_oe == '1));

    // R8
    pin_cmd_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && addr == 2'd3 && !din[7]) |=> $stable(mode_q));
endmodule

bind tri_port_pio tpp_checker #(.W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .dout_oe  (dout_oe),
    .wr_pulse (wr_pulse),
    .addr     (addr),
    .din      (din),
    .mode_q   (mode_q),
    .pa_oe    (pa_oe),
    .pc_oe    (pc_oe)
);

// File: tb/tri_port_pio_tb.sv
`timescale 1ns/1ps
module tri_port_pio_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic       cs_n = 1, rd_n = 1, wr_n = 1;
    logic [1:0] addr = 0;
    logic [7:0] din = 0;
    logic [7:0] pa_in = 8'h3C, pb_in = 8'h96, pc_in = 8'hA5;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       dout_oe;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    int         m_st;
    logic [7:0] m_mode, m_a, m_b, m_c;

    always #4 clk = ~clk;

    tri_port_pio dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Behavioural reference: stepped on each rising edge.
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_c = d;
            default: begin
                if (d[7]) begin
                    m_mode = d; m_a = 0; m_b = 0; m_c = 0;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_st = 0; m_mode = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
        end else begin
            case (m_st)
                0: if (!cs_n && !wr_n) begin m_st = 2; model_write(addr, din); end
                   else if (!cs_n && !rd_n) m_st = 1;
                1: if (cs_n || rd_n) m_st = 0;
                default: if (cs_n || wr_n) m_st = 0;
            endcase
        end
    end

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_mode[4] ? pa_in : m_a;
            2'd1: return m_mode[1] ? pb_in : m_b;
            2'd2: return {m_mode[3] ? pc_in[7:4] : m_c[7:4],
                          m_mode[0] ? pc_in[3:0] : m_c[3:0]};
            default: return m_mode;
        endcase
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            logic exp_oe;
            exp_oe = (m_st == 1) && !cs_n && !rd_n;
            chk("MODEL", "dout_oe", {7'd0, dout_oe}, {7'd0, exp_oe});
            if (exp_oe) chk("MODEL", "dout", dout, model_read(addr));
            chk("MODEL", "pa_out", pa_out, m_a);
            chk("MODEL", "pb_out", pb_out, m_b);
            chk("MODEL", "pc_out", pc_out, m_c);
            chk("MODEL", "pa_oe", pa_oe, m_mode[4] ? 8'h00 : 8'hFF);
            chk("MODEL", "pb_oe", pb_oe, m_mode[1] ? 8'h00 : 8'hFF);
            chk("MODEL", "pc_oe", pc_oe, {m_mode[3] ? 4'h0 : 4'hF, m_mode[0] ? 4'h0 : 4'hF});
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk) #1; cs_n = 0; wr_n = 0; addr = a; din = d;
        @(posedge clk) #1; cs_n = 1; wr_n = 1;
        @(posedge clk) #1;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk) #1; cs_n = 0; rd_n = 0; addr = a;
        @(negedge clk);
        chk(req, "oe before edge", {7'd0, dout_oe}, 8'd0);
        @(posedge clk); @(negedge clk);
        chk(req, "read data", dout, exp);
        chk(req, "read oe", {7'd0, dout_oe}, 8'd1);
        @(posedge clk) #1; cs_n = 1; rd_n = 1;
        @(negedge clk);
        chk("R2", "oe after release", {7'd0, dout_oe}, 8'd0);
    endtask

    task automatic pins(input string req, input logic [7:0] ea, eb, ec,
                        input logic [7:0] oa, ob, oc);
        @(negedge clk);
        chk(req, "pa_out", pa_out, ea); chk(req, "pb_out", pb_out, eb);
        chk(req, "pc_out", pc_out, ec); chk(req, "pa_oe", pa_oe, oa);
        chk(req, "pb_oe", pb_oe, ob);   chk(req, "pc_oe", pc_oe, oc);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL WATCHDOG run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R4 reset state
        pins("R4", 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        bus_rd(2'd3, 8'h9B, "R4");
        // R6 all inputs read pins
        bus_rd(2'd0, 8'h3C, "R6");
        bus_rd(2'd1, 8'h96, "R6");
        bus_rd(2'd2, 8'hA5, "R6");
        // R7 / R5 all outputs
        bus_wr(2'd3, 8'h80);
        bus_rd(2'd3, 8'h80, "R7");
        pins("R5", 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF);
        // R3 address map
        bus_wr(2'd0, 8'h5A);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'hF0);
        pins("R3", 8'h5A, 8'hC3, 8'hF0, 8'hFF, 8'hFF, 8'hFF);
        bus_rd(2'd0, 8'h5A, "R6");
        bus_rd(2'd2, 8'hF0, "R6");
        // R7 clears latches, R5 mixed directions
        bus_wr(2'd3, 8'h98);
        pins("R7", 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F);
        bus_rd(2'd2, 8'hA0, "R6");
        bus_rd(2'd0, 8'h3C, "R6");
        // R8 single-pin commands
        bus_wr(2'd3, 8'h03);
        pins("R8", 8'h00, 8'h00, 8'h02, 8'h00, 8'hFF, 8'h0F);
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd3, 8'h02);
        pins("R8", 8'h00, 8'h00, 8'h80, 8'h00, 8'hFF, 8'h0F);
        bus_rd(2'd3, 8'h98, "R8");
        // R1 deselected strobes ignored
        @(posedge clk) #1; cs_n = 1; wr_n = 0; addr = 2'd3; din = 8'h9B;
        @(posedge clk) #1; wr_n = 1; rd_n = 0;
        @(posedge clk); @(negedge clk);
        chk("R1", "oe while deselected", {7'd0, dout_oe}, 8'd0);
        @(posedge clk) #1; rd_n = 1;
        bus_rd(2'd3, 8'h98, "R1");
        // R9 mode-1 and mode-2 codes act as simple I/O
        bus_wr(2'd3, 8'hA4);
        bus_wr(2'd1, 8'h11);
        pins("R9", 8'h00, 8'h11, 8'h00, 8'hFF, 8'hFF, 8'hFF);
        bus_rd(2'd1, 8'h11, "R9");
        bus_rd(2'd3, 8'hA4, "R9");
        bus_wr(2'd3, 8'hD0);
        pins("R9", 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF);
        bus_rd(2'd0, 8'h3C, "R9");
        // R10 simultaneous strobes: write wins
        @(posedge clk) #1; cs_n = 0; rd_n = 0; wr_n = 0; addr = 2'd1; din = 8'h77;
        @(posedge clk); @(negedge clk);
        chk("R10", "oe", {7'd0, dout_oe}, 8'd0);
        chk("R10", "pb_out", pb_out, 8'h77);
        @(posedge clk) #1; cs_n = 1; rd_n = 1; wr_n = 1;
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule